// File: doc/BRIEF.md
# Serial Memory Status Register Controller

This block is the slave-side status-register logic of a serial nonvolatile memory attached to a mode-0 SPI bus. It watches the chip-select, serial-clock and serial-data-in pins through a synchronizer on the system clock. It decodes three instructions: set write enable, read status and write status. It keeps the write-enable latch and drives the serial-data-out pin while a status read is in progress.

An accepted write-status instruction does not change the register at once. It starts a write cycle whose length in system clock cycles is set by a parameter. The write-in-progress bit is 1 for the length of that cycle. The new register-lock and block-protect values, and the clearing of the write-enable latch, take effect only when the cycle ends. A write-protect pin, together with the register-lock bit, can put the register into a hardware-locked mode in which write-status does nothing. The two block-protect bits are also driven on an output port for the memory-array logic around this block.

The state machine has six states. `ST_IDLE` waits for chip select. `ST_OPCODE` shifts in the instruction byte. `ST_WDATA` shifts in the write-status data byte. `ST_ARM` holds a completed set-enable or write-status byte until chip select rises. `ST_READ` streams status bytes out. `ST_DROP` discards everything until chip select rises. The transitions are as follows. Any state goes to `ST_OPCODE` on a chip-select fall and to `ST_IDLE` on a chip-select rise. `ST_OPCODE` goes on its eighth clock rise to `ST_READ` (read status), to `ST_ARM` (set enable, not busy), to `ST_WDATA` (write status, not busy), or to `ST_DROP` (any other case). `ST_WDATA` goes to `ST_ARM` on its eighth rise. `ST_ARM` goes to `ST_DROP` on any further clock rise. The held instruction executes only on the chip-select rise out of `ST_ARM`.

Top module: `spi_sr_ctrl`

## Requirements
- R1: Opcode 0x06 (set enable), followed by chip select rising at the byte boundary, sets the enable latch. Opcode 0x05 (read status) returns the status byte MSB first. Each bit is shifted out on the falling clock edge. The status byte is bit 7 register lock, bits 6..4 zero, bits 3..2 block protect (bit 3 high), bit 1 enable latch, bit 0 write in progress.
- R2: A read-status instruction keeps returning the current status byte, byte after byte, for as long as chip select stays low.
- R3: Opcode 0x01 (write status) while the enable latch is 0 changes nothing.
- R4: A write status runs only if chip select rises after the clock rise that samples the eighth data bit and before the next clock rise. Rising earlier or later discards it and leaves the enable latch set.
- R5: An accepted write status makes bit 0 read 1 for exactly WC_CYCLES system cycles. Bit 0 then returns to 0. The status stays readable throughout.
- R6: The new register-lock and block-protect values appear in the status byte and on the `bp` port only when the write cycle ends. At that point the enable latch clears.
- R7: Only data bits 7, 3 and 2 are stored. Bits 6..4 always read 0, and data bits 1..0 have no effect.
- R8: When the register-lock bit is 1 and `wp_n` is low, write status is not executed and the enable latch stays 1. When `wp_n` is high or the lock bit is 0, it executes.
- R9: While bit 0 is 1, every opcode other than 0x05 is ignored, including 0x06 and 0x01.
- R10: After reset the status byte is 0x00, `bp` is 0 and `miso` is 0.
- R11: Any opcode other than 0x01, 0x05 and 0x06 is ignored along with all following bits until chip select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in, sampled on the sck rise |
| miso | output | 1 | Serial data out, changes on the sck fall, 0 when idle |
| wp_n | input | 1 | Write-protect pin, low asserts protection |
| bp | output | 2 | Current block-protect bits |

## Verification
Every pin edge passes two synchronizer flops and an edge register. A serial-clock fall therefore updates `miso` on the third system edge after it. The bench holds each serial-clock phase for six system cycles and samples `miso` at the end of the low phase, just before it raises the clock. A committed write shows on `bp` and in the status byte about WC_CYCLES plus three cycles after the chip-select rise. The bench waits WC_CYCLES plus 40 cycles before reading. It polls during the cycle only in windows that are known to fall well inside the busy time. The checker counts busy cycles against WC_CYCLES and requires register changes only in the cycle after the completion pulse.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

    localparam logic [7:0] OP_SET_EN  = 8'h06;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;

    // status byte layout
    localparam int SB_LOCK = 7;
    localparam int SB_BPH  = 3;
    localparam int SB_BPL  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_WDATA,
        ST_ARM,
        ST_READ,
        ST_DROP
    } sr_state_e;

    function automatic logic [7:0] pack_status(input logic lock, input logic [1:0] bpv,
                                               input logic en, input logic busy);
        return {lock, 3'b000, bpv, en, busy};
    endfunction

endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    assign lvl_o = sync_q;
endmodule

// File: rtl/spi_sr_edge.sv
module spi_sr_edge #(
    parameter logic RST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/spi_sr_wcycle.sv
module spi_sr_wcycle import spi_sr_pkg::*; #(
    parameter int CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] data_i,
    input  logic       set_en_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       en_o,
    output logic       lock_o,
    output logic [1:0] bp_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [2:0]    pend_q;
    logic          en_q;
    logic          lock_q;
    logic [1:0]    bp_q;

    assign done_o = busy_q && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            pend_q <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(CYCLES - 1);
            pend_q <= {data_i[SB_LOCK], data_i[SB_BPH], data_i[SB_BPL]};
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            lock_q <= 1'b0;
            bp_q   <= '0;
        end else if (done_o) begin
            en_q   <= 1'b0;
            lock_q <= pend_q[2];
            bp_q   <= pend_q[1:0];
        end else if (set_en_i) begin
            en_q   <= 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign en_o   = en_q;
    assign lock_o = lock_q;
    assign bp_o   = bp_q;
endmodule

// File: rtl/spi_sr_fsm.sv
module spi_sr_fsm import spi_sr_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_rise,
    input  logic       cs_fall,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       mosi,
    input  logic       wp_n,
    input  logic       busy,
    input  logic       en,
    input  logic       lock,
    input  logic [7:0] status,
    output logic       set_en,
    output logic       wr_start,
    output logic [7:0] wr_data,
    output logic       miso
);
    sr_state_e  state_q, state_d;
    logic [2:0] bit_cnt_q;
    logic [7:0] shin_q;
    logic       arm_wr_q;
    logic [6:0] obuf_q;
    logic [2:0] ocnt_q;
    logic       miso_q;
    logic [7:0] byte_in;
    logic       last_bit;
    logic       fire;

    assign byte_in  = {shin_q[6:0], mosi};
    assign last_bit = sck_rise && (bit_cnt_q == 3'd7);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cs_rise) begin
            state_d = ST_IDLE;
        end else if (cs_fall) begin
            state_d = ST_OPCODE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_READ, ST_DROP: state_d = state_q;
                ST_OPCODE: begin
                    if (last_bit) begin
                        if (byte_in == OP_RD_STAT)      state_d = ST_READ;
                        else if (busy)                  state_d = ST_DROP;
                        else if (byte_in == OP_SET_EN)  state_d = ST_ARM;
                        else if (byte_in == OP_WR_STAT) state_d = ST_WDATA;
                        else                            state_d = ST_DROP;
                    end
                end
                ST_WDATA: if (last_bit) state_d = ST_ARM;
                ST_ARM:   if (sck_rise) state_d = ST_DROP;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        fire     = cs_rise && (state_q == ST_ARM);
        set_en   = fire && !arm_wr_q && !busy;
        wr_start = fire && arm_wr_q && en && !busy && (!lock || wp_n);
        wr_data  = shin_q;
        miso     = miso_q;
    end

    // shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shin_q    <= '0;
            arm_wr_q  <= 1'b0;
            obuf_q    <= '0;
            ocnt_q    <= '0;
            miso_q    <= 1'b0;
        end else begin
            if (cs_fall) begin
                bit_cnt_q <= '0;
                ocnt_q    <= '0;
            end else if (sck_rise && (state_q == ST_OPCODE || state_q == ST_WDATA)) begin
                shin_q    <= byte_in;
                bit_cnt_q <= bit_cnt_q + 3'd1;
            end

            if (state_q == ST_OPCODE && state_d == ST_ARM)     arm_wr_q <= 1'b0;
            else if (state_q == ST_WDATA && state_d == ST_ARM) arm_wr_q <= 1'b1;

            if (cs_rise) begin
                miso_q <= 1'b0;
            end else if (sck_fall && state_q == ST_READ) begin
                // fresh snapshot at each byte start keeps the busy bit live
                if (ocnt_q == 3'd0) {miso_q, obuf_q} <= status;
                else                {miso_q, obuf_q} <= {obuf_q, 1'b0};
                ocnt_q <= ocnt_q + 3'd1;
            end
        end
    end
endmodule

// File: rtl/spi_sr_ctrl.sv
module spi_sr_ctrl import spi_sr_pkg::*; #(
    parameter int WC_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    output logic       miso,
    input  logic       wp_n,
    output logic [1:0] bp
);
    localparam int              NPIN    = 4;
    localparam int              PI_CS   = 3;
    localparam int              PI_SCK  = 2;
    localparam int              PI_MOSI = 1;
    localparam int              PI_WP   = 0;
    localparam logic [NPIN-1:0] PIN_RST = 4'b1001;
    localparam int              NEDGE   = 2;

    logic [NPIN-1:0]  pin_lvl;
    logic [NEDGE-1:0] rise_v, fall_v;
    logic cs_rise, cs_fall, sck_rise, sck_fall;
    logic busy, wc_done, wc_start, set_en, wel, lock;
    logic [7:0] wr_data, status;

    spi_sr_sync #(.W(NPIN), .RST_VAL(PIN_RST)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({cs_n, sck, mosi, wp_n}),
        .lvl_o (pin_lvl)
    );

    // edge detectors for the sck (index 0) and cs (index 1) lines
    for (genvar g = 0; g < NEDGE; g++) begin : g_edge
        spi_sr_edge #(.RST(PIN_RST[PI_SCK + g])) edge_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (pin_lvl[PI_SCK + g]),
            .rise_o (rise_v[g]),
            .fall_o (fall_v[g])
        );
    end

    assign sck_rise = rise_v[PI_SCK - 2];
    assign sck_fall = fall_v[PI_SCK - 2];
    assign cs_rise  = rise_v[PI_CS - 2];
    assign cs_fall  = fall_v[PI_CS - 2];

    assign status = pack_status(lock, bp, wel, busy);

    spi_sr_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_rise  (cs_rise),
        .cs_fall  (cs_fall),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi     (pin_lvl[PI_MOSI]),
        .wp_n     (pin_lvl[PI_WP]),
        .busy     (busy),
        .en       (wel),
        .lock     (lock),
        .status   (status),
        .set_en   (set_en),
        .wr_start (wc_start),
        .wr_data  (wr_data),
        .miso     (miso)
    );

    spi_sr_wcycle #(.CYCLES(WC_CYCLES)) wcyc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (wc_start),
        .data_i   (wr_data),
        .set_en_i (set_en),
        .busy_o   (busy),
        .done_o   (wc_done),
        .en_o     (wel),
        .lock_o   (lock),
        .bp_o     (bp)
    );
endmodule

// File: rtl/spi_sr_ctrl_chk.sv
module spi_sr_ctrl_chk #(
    parameter int WC_CYCLES = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       wc_start,
    input logic       wc_done,
    input logic       wel,
    input logic       lock,
    input logic [1:0] bp,
    input logic       wp_lvl,
    input logic       sck_fall,
    input logic       cs_rise,
    input logic       miso
);
    localparam int RW = $clog2(WC_CYCLES + 1) + 1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    // R5: busy never outlasts the write-cycle length
    a_r5_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RW'(WC_CYCLES)));

    // R5: busy lasts the full write-cycle length
    a_r5_busy_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(run_q) == RW'(WC_CYCLES - 1)));

    // R6: lock and protect bits move only after completion
    a_r6_commit_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !wc_done |=> $stable({lock, bp}));

    // R6: enable latch clears at completion
    a_r6_en_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        wc_done |=> !wel);

    // R9: no new write cycle starts while one runs
    a_r9_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wc_start |-> !busy);

    // R8: hardware lock blocks the write
    a_r8_hw_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !wp_lvl) |-> !wc_start);

    // R1: serial output moves only after a clock fall or deselect
    a_r1_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_fall || cs_rise) |=> $stable(miso));
endmodule

bind spi_sr_ctrl spi_sr_ctrl_chk #(.WC_CYCLES(WC_CYCLES)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .wc_start (wc_start),
    .wc_done  (wc_done),
    .wel      (wel),
    .lock     (lock),
    .bp       (bp),
    .wp_lvl   (pin_lvl[0]),
    .sck_fall (sck_fall),
    .cs_rise  (cs_rise),
    .miso     (miso)
);

// File: tb/spi_sr_ctrl_tb_top.sv
module spi_sr_ctrl_tb_top;
    localparam int WC = 400;
    localparam int H  = 6;
    localparam int NV = 6;
    // {wp_n, data byte, expected status}
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 8'hFF, 8'h8C},
        {1'b0, 8'h00, 8'h8E},
        {1'b1, 8'h04, 8'h04},
        {1'b0, 8'h78, 8'h08},
        {1'b0, 8'h83, 8'h80},
        {1'b1, 8'h0C, 8'h0C}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, cs_n, sck, mosi, wp_n, miso;
    logic [1:0] bp;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    spi_sr_ctrl #(.WC_CYCLES(WC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .miso(miso), .wp_n(wp_n), .bp(bp)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic halfwait();
        repeat (H) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i >= 8 - n; i--) begin
            mosi = tx[i];
            halfwait();
            rx[i] = miso;
            sck = 1'b1;
            halfwait();
            sck = 1'b0;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        halfwait();
    endtask

    task automatic desel();
        halfwait();
        cs_n = 1'b1;
        repeat (2 * H) @(negedge clk);
    endtask

    task automatic cmd_en();
        logic [7:0] d;
        sel(); xfer(8'h06, 8, d); desel();
    endtask

    task automatic cmd_wr(input logic [7:0] v);
        logic [7:0] d;
        sel(); xfer(8'h01, 8, d); xfer(v, 8, d); desel();
    endtask

    task automatic cmd_rd(output logic [7:0] s);
        logic [7:0] d;
        sel(); xfer(8'h05, 8, d); xfer(8'h00, 8, s); desel();
    endtask

    task automatic settle();
        repeat (WC + 40) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, a, b, d;
        int nbusy;
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; wp_n = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10 reset state
        check8("R10 miso", {7'd0, miso}, 8'h00);
        check8("R10 bp", {6'd0, bp}, 8'h00);
        cmd_rd(s);
        check8("R10 status", s, 8'h00);

        // vector table: set enable, write status, wait, read back
        for (int v = 0; v < NV; v++) begin
            wp_n = VEC[v][16];
            cmd_en();
            cmd_wr(VEC[v][15:8]);
            settle();
            cmd_rd(s);
            check8($sformatf("R7 R8 vector %0d status", v), s, VEC[v][7:0]);
            check8($sformatf("R6 vector %0d bp", v), {6'd0, bp}, {6'd0, VEC[v][3:2]});
        end
        wp_n = 1'b1;

        // R3 write without enable latch
        cmd_wr(8'h00);
        settle();
        cmd_rd(s);
        check8("R3 no enable", s, 8'h0C);
        check8("R3 bp", {6'd0, bp}, 8'h03);

        // R1 set enable
        cmd_en();
        cmd_rd(s);
        check8("R1 enable set", s, 8'h0E);

        // R2 continuous read
        sel(); xfer(8'h05, 8, d); xfer(8'h00, 8, a); xfer(8'h00, 8, b); desel();
        check8("R2 byte 1", a, 8'h0E);
        check8("R2 byte 2", b, 8'h0E);

        // R4 early deselect (7 data bits)
        sel(); xfer(8'h01, 8, d); xfer(8'h00, 7, d); desel();
        settle();
        cmd_rd(s);
        check8("R4 early", s, 8'h0E);

        // R4 late deselect (9 data bits)
        sel(); xfer(8'h01, 8, d); xfer(8'h00, 8, d); xfer(8'h00, 1, d); desel();
        settle();
        cmd_rd(s);
        check8("R4 late", s, 8'h0E);

        // R11 unknown opcode
        sel(); xfer(8'hA5, 8, d); xfer(8'hFF, 8, d); xfer(8'h01, 8, d); desel();
        cmd_rd(s);
        check8("R11 unknown opcode", s, 8'h0E);

        // R5 R6 poll during the write cycle
        cmd_wr(8'h00);
        sel(); xfer(8'h05, 8, d); xfer(8'h00, 8, a);
        check8("R5 busy seen", a, 8'h0F);
        check8("R6 bp held during cycle", {6'd0, bp}, 8'h03);
        nbusy = 1;
        s = a;
        for (int k = 0; k < 12; k++) begin
            xfer(8'h00, 8, s);
            if (s[0] == 1'b0) break;
            nbusy++;
        end
        desel();
        check8("R5 R6 after cycle", s, 8'h00);
        check8("R5 busy bytes bounded", {7'd0, (nbusy < 8)}, 8'h01);
        check8("R6 bp after cycle", {6'd0, bp}, 8'h00);

        // R9 commands during busy ignored
        cmd_en();
        cmd_wr(8'h0C);
        cmd_en();
        cmd_wr(8'h80);
        settle();
        cmd_rd(s);
        check8("R9 busy ignore", s, 8'h0C);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule